// File: doc/BRIEF.md
# Double-Buffered 10-Bit PWM Generator

This block drives one pulse-width-modulated output from an 8-bit period timer. A single sub-tick counter divides the input clock by 4 × prescale, with a prescale of 1, 4 or 16. The timer counts from zero up to the value on the period input and then starts again. The output rises at the start of each period and falls when a 10-bit time base equals the active duty value. That time base is the timer with two finer bits below it, taken from the sub-tick counter.

Software loads a 10-bit duty value (an 8-bit upper part and a 2-bit lower part) into a holding register through a write strobe, and may do so at any time. The value only reaches the active duty register when a period ends, so a period never runs with a mix of old and new settings. A one-cycle strobe marks every period start, and the active duty can be read back.

Top module: `pwm10_top`

## Requirements
- R1: While `rstN` is low, `pwmOut`, `periodStrobe` and `actDuty` are 0. Reset also clears the holding register, so a write made during reset is lost.
- R2: `periodStrobe` is high for exactly one cycle at the start of each period. The period lasts (periodVal+1) × 4 × prescale clocks. With prescale 1, the first strobe after reset release or enable comes that many clocks after the first running cycle.
- R3: `preSel` selects the prescale: code 0 gives 1, code 1 gives 4, and codes 2 and 3 give 16.
- R4: The active duty value is {dutyHi, dutyLo}, with dutyLo as the two least significant bits. If it is non-zero, `pwmOut` is high in the strobe cycle and stays high for exactly duty × prescale clocks of the period.
- R5: An active duty of 0 keeps `pwmOut` low for the whole period, including the strobe cycle.
- R6: An active duty of 4 × (periodVal+1) or more never matches the time base, so `pwmOut` stays high for the whole period.
- R7: `dutyWe` captures {dutyHi, dutyLo} into the holding register. `actDuty` takes the holding value only at a period start, so a write in mid-period does not change `actDuty` or the current pulse.
- R8: A write made in the last cycle of a period lands in the holding register on the same edge that loads `actDuty`. `actDuty` takes the previous holding value, and the new value takes effect one period later.
- R9: While `en` is low, `pwmOut` and `periodStrobe` stay low and the counters are held at zero. After `en` rises, `pwmOut` stays low until the first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low holds the counters and the output low |
| periodVal | input | 8 | Last timer count of a period |
| preSel | input | 2 | Prescale code (0:1, 1:4, 2/3:16) |
| dutyWe | input | 1 | Write strobe for the duty holding register |
| dutyHi | input | 8 | Upper 8 bits of the duty value |
| dutyLo | input | 2 | Lower 2 bits of the duty value |
| pwmOut | output | 1 | PWM output |
| periodStrobe | output | 1 | One-cycle pulse at each period start |
| actDuty | output | 10 | Read-back of the active duty |

## Verification
Two events can fall on the same clock edge: a software write to the duty holding register and the period-end transfer from the holding register to the active duty. The bench counts clocks from a strobe and raises `dutyWe` in the final cycle of a known-length period. It then checks that the strobe shows the old holding value in `actDuty` and that the new value appears one strobe later. The same edge also carries the duty-clear compare and the period-start set. Duties of 4·P+3 and 4·P+4 provoke this case, and it is judged by counting high clocks per period.

// File: rtl/pwm10_pkg.sv
`timescale 1ns/1ps
package pwm10_pkg;
  // Fine time-base bits below the timer; fixed by the 4-clock tick structure.
  localparam int FRAC_W = 2;

  // Strobes from control to datapath.
  typedef struct packed {
    logic                hold;    // enable low: force counters and output to zero
    logic                adv;     // timer advances on this edge
    logic                wrap;    // period end: timer clears, active duty loads
    logic [FRAC_W-1:0]   lowNxt;  // fine time-base bits after this edge
  } pwmCtl_t;
endpackage

// File: rtl/pwm10_ctrl.sv
`timescale 1ns/1ps
module pwm10_ctrl
  import pwm10_pkg::*;
#(
  parameter int TMR_W       = 8,
  parameter int PRE_LOG_MAX = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic [1:0]       preSel,
  input  logic [TMR_W-1:0] tmrVal,
  input  logic [TMR_W-1:0] periodVal,
  output pwmCtl_t          ctl,
  output logic [FRAC_W-1:0] lowNow
);
  localparam int SUB_W   = FRAC_W + PRE_LOG_MAX;
  localparam int LOG_W   = $clog2(PRE_LOG_MAX + 1);
  localparam int MID_LOG = (PRE_LOG_MAX >= 2) ? 2 : PRE_LOG_MAX;
  localparam logic [SUB_W-1:0] LAST_LO  = SUB_W'((1 << FRAC_W) - 1);
  localparam logic [SUB_W-1:0] LAST_MID = SUB_W'((1 << (FRAC_W + MID_LOG)) - 1);
  localparam logic [SUB_W-1:0] LAST_HI  = SUB_W'((1 << (FRAC_W + PRE_LOG_MAX)) - 1);

  logic [SUB_W-1:0] subCnt, subNxt, subLast;
  logic [LOG_W-1:0] preLog;
  logic             tickEnd;

  always_comb begin
    case (preSel)
      2'd0:    begin preLog = LOG_W'(0);           subLast = LAST_LO;  end
      2'd1:    begin preLog = LOG_W'(MID_LOG);     subLast = LAST_MID; end
      default: begin preLog = LOG_W'(PRE_LOG_MAX); subLast = LAST_HI;  end
    endcase
  end

  // >= so that a prescale change to a shorter tick in mid-tick ends it at once
  assign tickEnd = (subCnt >= subLast);

  always_comb begin
    if (!en)          subNxt = '0;
    else if (tickEnd) subNxt = '0;
    else              subNxt = subCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) subCnt <= '0;
    else       subCnt <= subNxt;
  end

  always_comb begin
    ctl.hold   = !en;
    ctl.adv    = en && tickEnd;
    ctl.wrap   = en && tickEnd && (tmrVal == periodVal);
    ctl.lowNxt = FRAC_W'(subNxt >> preLog);
  end

  assign lowNow = FRAC_W'(subCnt >> preLog);
endmodule

// File: rtl/pwm10_dp.sv
`timescale 1ns/1ps
module pwm10_dp
  import pwm10_pkg::*;
#(
  parameter int TMR_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  pwmCtl_t                 ctl,
  input  logic                    dutyWe,
  input  logic [TMR_W-1:0]        dutyHi,
  input  logic [FRAC_W-1:0]       dutyLo,
  output logic [TMR_W-1:0]        tmrVal,
  output logic                    pwmOut,
  output logic                    periodStrobe,
  output logic [TMR_W+FRAC_W-1:0] actDuty
);
  localparam int DUTY_W = TMR_W + FRAC_W;

  logic [TMR_W-1:0]  tmrNxt;
  logic [DUTY_W-1:0] holdDuty, tbNxt;
  logic              outNxt;

  always_comb begin
    if (ctl.hold || ctl.wrap) tmrNxt = '0;
    else if (ctl.adv)         tmrNxt = tmrVal + 1'b1;
    else                      tmrNxt = tmrVal;
  end

  assign tbNxt = {tmrNxt, ctl.lowNxt};

  // Output is registered against the next time base so that it changes
  // on the same edge as the count it refers to.
  always_comb begin
    if (ctl.hold)                outNxt = 1'b0;
    else if (ctl.wrap)           outNxt = (holdDuty != '0);
    else if (tbNxt == actDuty)   outNxt = 1'b0;
    else                         outNxt = pwmOut;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmrVal       <= '0;
      holdDuty     <= '0;
      actDuty      <= '0;
      pwmOut       <= 1'b0;
      periodStrobe <= 1'b0;
    end else begin
      tmrVal       <= tmrNxt;
      pwmOut       <= outNxt;
      periodStrobe <= ctl.wrap;
      if (dutyWe)   holdDuty <= {dutyHi, dutyLo};
      if (ctl.wrap) actDuty  <= holdDuty;
    end
  end
endmodule

// File: rtl/pwm10_top.sv
`timescale 1ns/1ps
module pwm10_top
  import pwm10_pkg::*;
#(
  parameter int TMR_W       = 8,
  parameter int PRE_LOG_MAX = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    en,
  input  logic [TMR_W-1:0]        periodVal,
  input  logic [1:0]              preSel,
  input  logic                    dutyWe,
  input  logic [TMR_W-1:0]        dutyHi,
  input  logic [FRAC_W-1:0]       dutyLo,
  output logic                    pwmOut,
  output logic                    periodStrobe,
  output logic [TMR_W+FRAC_W-1:0] actDuty
);
  pwmCtl_t           ctl;
  logic [TMR_W-1:0]  tmrVal;
  logic [FRAC_W-1:0] lowNow;

  pwm10_ctrl #(.TMR_W(TMR_W), .PRE_LOG_MAX(PRE_LOG_MAX)) uCtrl (
    .clk(clk), .rstN(rstN), .en(en), .preSel(preSel),
    .tmrVal(tmrVal), .periodVal(periodVal), .ctl(ctl), .lowNow(lowNow)
  );

  pwm10_dp #(.TMR_W(TMR_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dutyWe(dutyWe),
    .dutyHi(dutyHi), .dutyLo(dutyLo), .tmrVal(tmrVal),
    .pwmOut(pwmOut), .periodStrobe(periodStrobe), .actDuty(actDuty)
  );
endmodule

// File: rtl/pwm10_chk.sv
`timescale 1ns/1ps
module pwm10_chk #(
  parameter int TMR_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               en,
  input logic               pwmOut,
  input logic               periodStrobe,
  input logic [TMR_W+1:0]   actDuty,
  input logic [TMR_W-1:0]   tmrVal,
  input logic [1:0]         lowNow
);
  a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    periodStrobe |=> !periodStrobe);

  a_r2_strobe_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    periodStrobe |-> (tmrVal == '0 && lowNow == '0));

  a_r4_rise_at_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwmOut) |-> periodStrobe);

  a_r5_start_level: assert property (@(posedge clk) disable iff (!rstN)
    periodStrobe |-> (pwmOut == (actDuty != '0)));

  a_r7_active_moves_at_start: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(actDuty) |-> periodStrobe);

  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> (!pwmOut && !periodStrobe && tmrVal == '0));
endmodule

bind pwm10_top pwm10_chk #(.TMR_W(TMR_W)) u_chk (
  .clk(clk), .rstN(rstN), .en(en), .pwmOut(pwmOut),
  .periodStrobe(periodStrobe), .actDuty(actDuty),
  .tmrVal(tmrVal), .lowNow(lowNow)
);

// File: tb/sim_pwm10_top.sv
`timescale 1ns/1ps
module sim_pwm10_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       en = 1'b0;
  logic [7:0] periodVal = '0;
  logic [1:0] preSel = '0;
  logic       dutyWe = 1'b0;
  logic [7:0] dutyHi = '0;
  logic [1:0] dutyLo = '0;
  logic       pwmOut, periodStrobe;
  logic [9:0] actDuty;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  pwm10_top u0 (
    .clk(clk), .rstN(rstN), .en(en), .periodVal(periodVal), .preSel(preSel),
    .dutyWe(dutyWe), .dutyHi(dutyHi), .dutyLo(dutyLo),
    .pwmOut(pwmOut), .periodStrobe(periodStrobe), .actDuty(actDuty)
  );

  always #5 clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int preOf(input int s);
    return (s == 0) ? 1 : ((s == 1) ? 4 : 16);
  endfunction

  task automatic waitStrobe(output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!periodStrobe && n < 40000);
  endtask

  task automatic writeDuty(input int d);
    dutyHi = 8'(d >> 2);
    dutyLo = 2'(d & 3);
    dutyWe = 1'b1;
    step();
    dutyWe = 1'b0;
  endtask

  // Called in a strobe cycle; returns in the next strobe cycle.
  task automatic runConfig(input int p, input int s, input int d);
    int n, cyc, hi, len, expHi, full;
    string tag;
    periodVal = 8'(p);
    preSel = 2'(s);
    writeDuty(d);
    waitStrobe(n);
    chk("R7", "active duty after period start", int'(actDuty), d);
    len = (p + 1) * 4 * preOf(s);
    full = 4 * (p + 1);
    expHi = ((d < full) ? d : full) * preOf(s);
    tag = (d == 0) ? "R5" : ((d >= full) ? "R6" : "R4");
    chk(tag, "level in strobe cycle", int'(pwmOut), (d != 0) ? 1 : 0);
    cyc = 0;
    hi = 0;
    do begin
      hi += int'(pwmOut);
      step();
      cyc++;
      if (cyc == 1) chk("R2", "strobe one cycle wide", int'(periodStrobe), 0);
    end while (!periodStrobe && cyc < 40000);
    chk((s == 0) ? "R2" : "R3", $sformatf("period clocks P=%0d sel=%0d", p, s), cyc, len);
    chk(tag, $sformatf("high clocks P=%0d sel=%0d d=%0d", p, s, d), hi, expHi);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n, cyc, hi, bad;
    int pers[3] = '{0, 2, 7};
    // R1: reset with a write attempted during it
    rstN = 1'b0;
    en = 1'b1;
    periodVal = 8'd3;
    dutyHi = 8'hAA;
    dutyLo = 2'd2;
    dutyWe = 1'b1;
    repeat (3) step();
    chk("R1", "pwmOut in reset", int'(pwmOut), 0);
    chk("R1", "strobe in reset", int'(periodStrobe), 0);
    chk("R1", "actDuty in reset", int'(actDuty), 0);
    dutyWe = 1'b0;
    rstN = 1'b1;
    waitStrobe(n);
    chk("R2", "first strobe after reset", n, 16);
    chk("R1", "holding register cleared by reset", int'(actDuty), 0);
    chk("R5", "zero duty after reset keeps output low", int'(pwmOut), 0);

    // Sweep: periods, all prescale codes, duties around the edges
    for (int pi = 0; pi < 3; pi++) begin
      for (int s = 0; s < 4; s++) begin
        int p;
        int duties[7];
        p = pers[pi];
        duties = '{0, 1, 3, 2 * p + 1, 4 * p + 3, 4 * p + 4, 1023};
        for (int di = 0; di < 7; di++) runConfig(p, s, duties[di]);
      end
    end
    // Full 10-bit resolution
    runConfig(255, 0, 1023);
    runConfig(255, 0, 512);

    // R7: mid-period write leaves the running pulse alone
    runConfig(3, 0, 10);
    cyc = 0;
    hi = 0;
    do begin
      if (cyc == 2) begin dutyHi = 8'd1; dutyLo = 2'd1; dutyWe = 1'b1; end
      if (cyc == 3) dutyWe = 1'b0;
      if (cyc == 5) chk("R7", "actDuty unchanged mid-period", int'(actDuty), 10);
      hi += int'(pwmOut);
      step();
      cyc++;
    end while (!periodStrobe && cyc < 40000);
    dutyWe = 1'b0;
    chk("R7", "pulse of period with mid write uses old duty", hi, 10);
    chk("R7", "new duty active at next start", int'(actDuty), 5);

    // R8: write in the last cycle of a period (L = 16)
    cyc = 0;
    do begin
      if (cyc == 15) begin dutyHi = 8'd3; dutyLo = 2'd0; dutyWe = 1'b1; end
      step();
      dutyWe = 1'b0;
      cyc++;
    end while (!periodStrobe && cyc < 40000);
    chk("R8", "boundary write not yet active", int'(actDuty), 5);
    waitStrobe(n);
    chk("R8", "boundary write active one period later", int'(actDuty), 12);

    // R9: disable and restart
    repeat (3) step();
    chk("R4", "output high inside pulse", int'(pwmOut), 1);
    en = 1'b0;
    step();
    chk("R9", "output low after disable", int'(pwmOut), 0);
    bad = 0;
    for (int k = 0; k < 20; k++) begin
      bad += int'(pwmOut) + int'(periodStrobe);
      step();
    end
    chk("R9", "no output or strobe while disabled", bad, 0);
    en = 1'b1;
    n = 0;
    hi = 0;
    do begin
      hi += int'(pwmOut);
      step();
      n++;
    end while (!periodStrobe && n < 40000);
    chk("R9", "first strobe after enable", n, 16);
    chk("R9", "output low before first strobe", hi, 0);
    chk("R9", "output set at first strobe", int'(pwmOut), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule